// File: doc/BRIEF.md
# AC-Drive Static LCD Segment Driver

This block drives a static, non-multiplexed seven-segment liquid crystal panel with three full digits, a leading half digit that can only show "1", and a minus sign. It takes three binary-coded decimal digits, a half-digit enable and a negative flag, and produces one common backplane line plus one line per segment.

The liquid crystal must never see a steady voltage. The block therefore divides the oscillator clock into a square-wave backplane with a 50% duty cycle. Each segment line carries the same square wave as the backplane when the segment is dark, and its inverse when the segment is lit. The average voltage across every segment is then zero. With the default divider the backplane period is 800 oscillator clocks, so a 48 kHz oscillator gives a 60 Hz backplane.

The inputs are sampled into a holding register on every clock. The sampled values reach the panel only at the start of a backplane period, and the segment lines change only in the clock cycle in which the backplane changes. The two never drift apart, so no short steady-voltage pulse appears across a segment.

Top module: `lcd_static_driver`

## Requirements
- R1: The backplane toggles once every HALF_PERIOD clocks (default 400), giving a square wave of period 2*HALF_PERIOD with 50% duty. Its first rise comes HALF_PERIOD clocks after reset is released.
- R2: While reset is asserted, the backplane and every segment line are low. All segments are therefore dark and in phase with the backplane.
- R3: At all times a dark segment line equals the backplane and a lit segment line equals its inverse.
- R4: Digit k is taken from bcd_in[4k+3:4k], with digit 0 the least significant. Its seven segment lines are seg_digits[7k+6:7k], ordered {g,f,e,d,c,b,a} with a at the lowest bit. Codes 0 to 9 light the standard patterns (hex on-masks 3F,06,5B,4F,66,6D,7D,07,7F,6F).
- R5: A digit code from 10 to 15 leaves all seven segments of that digit dark.
- R6: Both half-digit lines seg_half = {c,b} are lit when half_en is 1 and dark when it is 0.
- R7: seg_minus is lit when neg_in is 1 and dark when it is 0.
- R8: Input values are applied to the panel only at a rising backplane edge. An input change made after a rising edge has no effect on the segment lines until the following rising edge.
- R9: The segment lines change only in a clock cycle in which the backplane also changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| bcd_in | input | 4*N_DIGITS | BCD digits, digit 0 in the low nibble |
| half_en | input | 1 | Light the leading half digit "1" |
| neg_in | input | 1 | Reading is negative; light the minus sign |
| backplane | output | 1 | Common backplane square wave |
| seg_digits | output | 7*N_DIGITS | Segment lines of the full digits, {g..a} per digit |
| seg_half | output | 2 | Half-digit segment lines {c,b} |
| seg_minus | output | 1 | Minus-sign segment line |

## Verification
The bench sweeps every combination of the sixteen codes over all three digits, with the half-digit and sign flags varied across the sweep. On each backplane edge it checks the whole segment pattern against an independently computed on-mask, taken in the correct phase. A wrong decode entry, an invalid code that lights something, or a swapped half-digit or minus line would show up as a mismatched field. After every rising edge the bench inverts all inputs. A design that passed data through before the next period boundary would show the inverted pattern at the falling edge, where the old one is expected. The bench also counts clocks between backplane edges and watches the segment lines between edges. An off-by-one divider, or segment lines that update apart from the backplane, would each break one of these checks.

// File: rtl/lcd_drv_pkg.sv
package lcd_drv_pkg;

    localparam int SEG7_W   = 7;
    localparam int BCD_W    = 4;
    localparam int HALF_W   = 2;
    localparam int EXTRA_W  = HALF_W + 1;

    typedef logic [SEG7_W-1:0] seg7_t;
    typedef logic [BCD_W-1:0]  bcd_t;

    typedef enum logic {
        BP_LOW  = 1'b0,
        BP_HIGH = 1'b1
    } bp_phase_e;

    typedef struct packed {
        logic minus;
        logic half_on;
    } sign_ctl_t;

    // Segment on-mask, bit order {g,f,e,d,c,b,a}
    function automatic seg7_t bcd_to_seg7(input bcd_t code);
        seg7_t m;
        unique case (code)
            4'd0:    m = 7'b0111111;
            4'd1:    m = 7'b0000110;
            4'd2:    m = 7'b1011011;
            4'd3:    m = 7'b1001111;
            4'd4:    m = 7'b1100110;
            4'd5:    m = 7'b1101101;
            4'd6:    m = 7'b1111101;
            4'd7:    m = 7'b0000111;
            4'd8:    m = 7'b1111111;
            4'd9:    m = 7'b1101111;
            default: m = 7'b0000000;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/lcd_bp_divider.sv
module lcd_bp_divider
    import lcd_drv_pkg::*;
#(
    parameter int HALF_PERIOD = 400
) (
    input  logic clk,
    input  logic rst,
    output logic bp,
    output logic edge_stb,
    output logic rise_stb
);

    localparam int CNT_W = (HALF_PERIOD > 1) ? $clog2(HALF_PERIOD) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_PERIOD - 1);

    logic [CNT_W-1:0] cnt_q;
    bp_phase_e        phase_q;

    assign edge_stb = (cnt_q == CNT_LAST);
    assign rise_stb = edge_stb && (phase_q == BP_LOW);
    assign bp       = phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            phase_q <= BP_LOW;
        end else if (edge_stb) begin
            cnt_q   <= '0;
            phase_q <= (phase_q == BP_LOW) ? BP_HIGH : BP_LOW;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/lcd_frame_latch.sv
module lcd_frame_latch
    import lcd_drv_pkg::*;
#(
    parameter int N_DIGITS = 3,
    localparam int SEG_W   = N_DIGITS * SEG7_W + EXTRA_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [N_DIGITS*BCD_W-1:0] bcd_in,
    input  sign_ctl_t                 ctl_in,
    input  logic                      rise_stb,
    output logic [SEG_W-1:0]          on_next
);

    logic [N_DIGITS*BCD_W-1:0] bcd_hold_q;
    sign_ctl_t                 ctl_hold_q;
    logic [SEG_W-1:0]          shown_q;
    logic [SEG_W-1:0]          decoded;

    always_ff @(posedge clk) begin
        if (rst) begin
            bcd_hold_q <= '0;
            ctl_hold_q <= '0;
        end else begin
            bcd_hold_q <= bcd_in;
            ctl_hold_q <= ctl_in;
        end
    end

    for (genvar k = 0; k < N_DIGITS; k++) begin : g_dec
        assign decoded[k*SEG7_W +: SEG7_W] =
            bcd_to_seg7(bcd_hold_q[k*BCD_W +: BCD_W]);
    end

    assign decoded[N_DIGITS*SEG7_W +: HALF_W] = {HALF_W{ctl_hold_q.half_on}};
    assign decoded[SEG_W-1]                   = ctl_hold_q.minus;

    assign on_next = rise_stb ? decoded : shown_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shown_q <= '0;
        end else begin
            shown_q <= on_next;
        end
    end

endmodule

// File: rtl/lcd_seg_phaser.sv
module lcd_seg_phaser #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         edge_stb,
    input  logic         bp_next,
    input  logic [W-1:0] on_next,
    output logic [W-1:0] seg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            seg_q <= '0;
        end else if (edge_stb) begin
            seg_q <= on_next ^ {W{bp_next}};
        end
    end

endmodule

// File: rtl/lcd_static_driver.sv
module lcd_static_driver
    import lcd_drv_pkg::*;
#(
    parameter int HALF_PERIOD = 400,
    parameter int N_DIGITS    = 3
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_DIGITS*BCD_W-1:0]  bcd_in,
    input  logic                       half_en,
    input  logic                       neg_in,
    output logic                       backplane,
    output logic [N_DIGITS*SEG7_W-1:0] seg_digits,
    output logic [HALF_W-1:0]          seg_half,
    output logic                       seg_minus
);

    localparam int SEG_W = N_DIGITS * SEG7_W + EXTRA_W;

    logic             bp;
    logic             edge_stb;
    logic             rise_stb;
    sign_ctl_t        ctl;
    logic [SEG_W-1:0] on_next;
    logic [SEG_W-1:0] seg_all;

    assign ctl.minus   = neg_in;
    assign ctl.half_on = half_en;

    lcd_bp_divider #(.HALF_PERIOD(HALF_PERIOD)) div_i (
        .clk      (clk),
        .rst      (rst),
        .bp       (bp),
        .edge_stb (edge_stb),
        .rise_stb (rise_stb)
    );

    lcd_frame_latch #(.N_DIGITS(N_DIGITS)) latch_i (
        .clk      (clk),
        .rst      (rst),
        .bcd_in   (bcd_in),
        .ctl_in   (ctl),
        .rise_stb (rise_stb),
        .on_next  (on_next)
    );

    lcd_seg_phaser #(.W(SEG_W)) phase_i (
        .clk      (clk),
        .rst      (rst),
        .edge_stb (edge_stb),
        .bp_next  (~bp),
        .on_next  (on_next),
        .seg_q    (seg_all)
    );

    assign backplane  = bp;
    assign seg_digits = seg_all[N_DIGITS*SEG7_W-1:0];
    assign seg_half   = seg_all[N_DIGITS*SEG7_W +: HALF_W];
    assign seg_minus  = seg_all[SEG_W-1];

endmodule

// File: rtl/lcd_static_driver_chk.sv
module lcd_static_driver_chk
    import lcd_drv_pkg::*;
#(
    parameter int HALF_PERIOD = 400,
    parameter int N_DIGITS    = 3
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       backplane,
    input logic [N_DIGITS*SEG7_W-1:0] seg_digits,
    input logic [HALF_W-1:0]          seg_half,
    input logic                       seg_minus
);

    localparam int SEG_W = N_DIGITS * SEG7_W + EXTRA_W;
    localparam int GAP_W = $clog2(HALF_PERIOD + 1) + 1;
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(HALF_PERIOD - 1);

    logic [SEG_W-1:0] seg_all;
    logic [SEG_W-1:0] rel_on;
    logic             bp_d;
    logic [GAP_W-1:0] gap_q;
    logic             rst_d;

    assign seg_all = {seg_minus, seg_half, seg_digits};
    assign rel_on  = seg_all ^ {SEG_W{backplane}};

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) begin
            bp_d  <= 1'b0;
            gap_q <= '1;
        end else begin
            bp_d  <= backplane;
            gap_q <= (backplane != bp_d) ? '0 : gap_q + 1'b1;
        end
    end

    always @(posedge clk) begin
        if (rst_d && rst) begin
            assert_reset_blank_R2 : assert (backplane == 1'b0 && seg_all == '0);
        end
    end

    assert_bp_toggle_gap_R1 : assert property (@(posedge clk) disable iff (rst)
        (backplane != bp_d) |-> (gap_q == GAP_LAST));

    assert_bp_no_early_R1 : assert property (@(posedge clk) disable iff (rst)
        (backplane == bp_d) |-> (gap_q != GAP_LAST));

    assert_on_kept_at_fall_R3 : assert property (@(posedge clk) disable iff (rst)
        $fell(backplane) |-> (rel_on == $past(rel_on)));

    assert_half_pair_R6 : assert property (@(posedge clk) disable iff (rst)
        seg_half[0] == seg_half[1]);

    assert_seg_with_bp_R9 : assert property (@(posedge clk) disable iff (rst)
        $stable(backplane) |-> $stable(seg_all));

endmodule

bind lcd_static_driver lcd_static_driver_chk #(
    .HALF_PERIOD (HALF_PERIOD),
    .N_DIGITS    (N_DIGITS)
) chk_i (.*);

// File: tb/lcd_static_driver_tb_top.sv
module lcd_static_driver_tb_top;

    localparam int HALF = 6;
    localparam int ND   = 3;
    localparam int W    = ND * 7 + 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [ND*4-1:0] bcd_in = '0;
    logic          half_en = 1'b0;
    logic          neg_in = 1'b0;
    logic          backplane;
    logic [ND*7-1:0] seg_digits;
    logic [1:0]    seg_half;
    logic          seg_minus;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    lcd_static_driver #(.HALF_PERIOD(HALF), .N_DIGITS(ND)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .bcd_in     (bcd_in),
        .half_en    (half_en),
        .neg_in     (neg_in),
        .backplane  (backplane),
        .seg_digits (seg_digits),
        .seg_half   (seg_half),
        .seg_minus  (seg_minus)
    );

    function automatic logic [6:0] ref_seg(input logic [3:0] c);
        case (c)
            4'd0: return 7'h3F;
            4'd1: return 7'h06;
            4'd2: return 7'h5B;
            4'd3: return 7'h4F;
            4'd4: return 7'h66;
            4'd5: return 7'h6D;
            4'd6: return 7'h7D;
            4'd7: return 7'h07;
            4'd8: return 7'h7F;
            4'd9: return 7'h6F;
            default: return 7'h00;
        endcase
    endfunction

    function automatic logic [W-1:0] ref_mask(input logic [ND*4-1:0] b,
                                              input logic h, input logic n);
        logic [W-1:0] m;
        for (int k = 0; k < ND; k++) m[k*7 +: 7] = ref_seg(b[k*4 +: 4]);
        m[ND*7 +: 2] = {h, h};
        m[W-1]       = n;
        return m;
    endfunction

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] seg_now();
        return {seg_minus, seg_half, seg_digits};
    endfunction

    // Wait for the next backplane change; check its spacing and that the
    // segment lines held still in between.
    task automatic wait_edge();
        logic         bp0 = backplane;
        logic [W-1:0] s0  = seg_now();
        bit           held = 1;
        int           n    = 0;
        do begin
            @(negedge clk);
            n++;
            if (backplane == bp0 && seg_now() !== s0) held = 0;
        end while (backplane == bp0 && n < 4 * HALF);
        check("R1 half-period clocks", W'(n), W'(HALF));
        check("R9 segments held between edges", W'(held), W'(1));
    endtask

    task automatic run_vector(input logic [ND*4-1:0] b, input logic h, input logic n);
        logic [W-1:0] exp = ref_mask(b, h, n);
        logic [W-1:0] act;
        bcd_in  = b;
        half_en = h;
        neg_in  = n;
        wait_edge();
        act = seg_now();
        check("R3 lit lines inverse of backplane", act, exp ^ {W{backplane}});
        for (int k = 0; k < ND; k++) begin
            if (b[k*4 +: 4] <= 4'd9)
                check("R4 digit decode", W'(act[k*7 +: 7] ^ {7{backplane}}), W'(exp[k*7 +: 7]));
            else
                check("R5 invalid code blank", W'(act[k*7 +: 7] ^ {7{backplane}}), W'(0));
        end
        check("R6 half digit", W'(act[ND*7 +: 2] ^ {2{backplane}}), W'({h, h}));
        check("R7 minus sign", W'(act[W-1] ^ backplane), W'(n));
        // change inputs mid-period: must not show until next rise
        bcd_in  = ~b;
        half_en = ~h;
        neg_in  = ~n;
        wait_edge();
        check("R8 mid-period change ignored", seg_now(), exp ^ {W{backplane}});
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R2 reset backplane low", W'(backplane), W'(0));
        check("R2 reset segments dark", seg_now(), '0);
        rst = 1'b0;
        for (int v = 0; v < 4096; v++) begin
            logic [11:0] vv = 12'(v);
            run_vector(vv[ND*4-1:0], vv[0] ^ vv[5], vv[1] ^ vv[10]);
        end
        finish_run();
    end

    initial begin
        #(150000 * 5);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

endmodule